// File: doc/BRIEF.md
# Receive Ring Buffer Packet Writer

This block takes received Ethernet frames as a byte stream marked with start-of-frame and end-of-frame flags and stores them in a paged circular buffer in local memory. It writes through a single byte-wide write port. A page is 256 bytes. The ring runs from a start page up to, but not including, a stop page. The host consumes frames and publishes how far it has read through a boundary page. The block owns the current page, which is where the next frame will be stored.

For each frame the block first decides whether there is room and whether the controller is running. It then checks the destination address against the station address, the broadcast and multicast enables and a 64-bit multicast hash.

The frame bytes of an accepted frame are stored four bytes past the start of the current page. Short frames are zero-padded, and the data wraps from the stop page back to the start page whenever it reaches the end of the ring. Once the frame is complete, the block fills in a four-byte header at the start of the current page. It then moves the current page to the next free page and pulses a one-cycle receive strobe.

Top module: `rxr_ring_writer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `cur_pg` to 0 and drives `mem_we` and `rx_ok` low.
- R2: A frame whose first byte arrives while `rx_stop` is high is dropped. It produces no memory write, `cur_pg` does not move and `rx_ok` does not pulse.
- R3: At the start of a frame the free space is computed in pages. It is `boundary_pg - cur_pg` when `cur_pg < boundary_pg`, and otherwise `(ring_stop_pg - ring_start_pg) - (cur_pg - boundary_pg)`. If that space times 256 is below 1518 bytes, the frame is dropped. When the boundary equals the current page, the whole ring counts as free.
- R4: With `accept_all` high, every frame of 6 bytes or more is accepted, whatever its destination.
- R5: A destination of all-ones bytes is accepted only when `accept_bcast` is high. It is never judged by the multicast hash.
- R6: A non-broadcast destination whose first byte has bit 0 set is accepted only when `accept_mcast` is high and `mcast_hash[idx]` is set. The index idx is formed from the six destination bytes as follows. Start with a 32-bit register at all ones. Feed the 48 address bits in wire order, least significant bit of byte 0 first. For each bit, shift the register left by one, and XOR in 0x04C11DB7 when the old top bit differs from the input bit. idx is the top six bits of the final register.
- R7: A destination with bit 0 of byte 0 clear is accepted only when all six bytes equal `station_addr`, where byte 0 of the destination is compared with `station_addr[7:0]`.
- R8: An accepted frame shorter than 60 bytes is stored padded with zero bytes up to 60 bytes. A frame that ends before its sixth byte is dropped.
- R9: The header at byte offsets 0 to 3 of the frame's first page holds the following, in order: a status byte, the next page, and the stored length plus 4 as a 16-bit little-endian value. The status byte is 0x01, or 0x21 when bit 0 of destination byte 0 is set.
- R10: The next page equals `cur_pg + floor((L + 8 + 255) / 256)`, with L the stored (padded) length. When that value is at or beyond `ring_stop_pg`, the ring size is subtracted from it.
- R11: Frame bytes go to consecutive addresses starting at `{cur_pg, 8'h04}`. The address that follows the last byte below the stop page is the first byte of the start page, and all writes stay inside the ring.
- R12: In the same cycle as the final header byte write, `cur_pg` takes the next page and `rx_ok` is high for exactly that one cycle. Input beats that arrive while a previous frame is still being padded or given its header are ignored. This includes any start-of-frame among them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_stop | input | 1 | Controller stopped; new frames are dropped |
| accept_all | input | 1 | Promiscuous reception |
| accept_bcast | input | 1 | Accept all-ones destination |
| accept_mcast | input | 1 | Accept hashed group destinations |
| mcast_hash | input | 64 | Multicast hash filter bits |
| station_addr | input | 48 | Own address, byte 0 in bits 7:0 |
| ring_start_pg | input | PAGE_W | First page of the ring |
| ring_stop_pg | input | PAGE_W | Page just past the ring |
| boundary_pg | input | PAGE_W | Host read boundary page |
| cur_load | input | 1 | Load `cur_load_pg` into the current page (taken only between frames) |
| cur_load_pg | input | PAGE_W | Value for the current page load |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| mem_we | output | 1 | Buffer write enable |
| mem_addr | output | PAGE_W+8 | Buffer byte address |
| mem_wdata | output | 8 | Buffer write byte |
| cur_pg | output | PAGE_W | Current page |
| rx_ok | output | 1 | One-cycle strobe per stored frame |

## Verification
The bench concentrates on the page-rounding edges. It uses 248 and 249-byte frames, which sit on either side of a one-page versus two-page span. It also sends a next page that lands exactly on the stop page. An off-by-one in the rounding or in the wrap test would leave `cur_pg` one page off, or parked on the stop page. Frames that cross the stop page mid-data would show up as bytes written past the ring, or with a corrupted payload, if the wrap address were wrong.

The free-space test is probed at five pages (dropped) and six pages (accepted), on both sides of the boundary and with the boundary equal to the current page. A wrong comparison would either overrun unread data or refuse frames while the ring is empty. Runts, broadcast-versus-hash confusion, and a start-of-frame arriving during the header phase are each set up so that a mishandling design moves `cur_pg` or pulses `rx_ok` when it must not.

// File: rtl/rxr_pkg.sv
// Shared types and helpers for the receive ring writer.
// Assumes destination addresses are packed with byte 0 in bits 7:0.
package rxr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_SKIP,
        ST_PAD,
        ST_HDR
    } rxr_state_e;

    localparam int HDR_BYTES  = 4;
    localparam int DEST_BYTES = 6;

    // Serial CRC over the destination, bits fed LSB-first per byte; top six bits index the hash.
    function automatic logic [5:0] hash_index(input logic [47:0] dest);
        logic [31:0] crc;
        logic        fb;
        crc = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            fb  = crc[31] ^ dest[i];
            crc = {crc[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0000_0000);
        end
        return crc[31:26];
    endfunction

endpackage

// File: rtl/rxr_addr_filter.sv
// Destination address filter: decides acceptance of a frame from its
// six destination bytes and the filter configuration. Purely combinational.
// Assumes dest byte 0 (first on the wire) sits in bits 7:0.
module rxr_addr_filter
    import rxr_pkg::*;
(
    input  logic [47:0] dest,
    input  logic [47:0] station_addr,
    input  logic [63:0] mcast_hash,
    input  logic        accept_all,
    input  logic        accept_bcast,
    input  logic        accept_mcast,
    output logic        accept,
    output logic        is_group
);

    logic       is_bcast;
    logic       is_mcast;
    logic [5:0] hidx;

    // Classify the destination and combine with the enables.
    always_comb begin
        is_bcast = &dest;
        is_group = dest[0];
        is_mcast = dest[0] && !is_bcast;
        hidx     = hash_index(dest);
        accept   = accept_all
                 | (is_bcast && accept_bcast)
                 | (is_mcast && accept_mcast && mcast_hash[hidx])
                 | (!dest[0] && (dest == station_addr));
    end

endmodule

// File: rtl/rxr_space_check.sv
// Ring free-space test: flags the ring as full when the pages between the
// current page and the host boundary cannot hold a maximum frame plus header.
// Assumes start < stop and all pages inside the ring.
module rxr_space_check #(
    parameter int PAGE_W    = 8,
    parameter int MAX_FRAME = 1514,
    parameter int HDR       = 4
) (
    input  logic [PAGE_W-1:0] cur_pg,
    input  logic [PAGE_W-1:0] bnd_pg,
    input  logic [PAGE_W-1:0] start_pg,
    input  logic [PAGE_W-1:0] stop_pg,
    output logic              full
);

    localparam int EW      = PAGE_W + 2;
    localparam int NEED_PG = (MAX_FRAME + HDR + 255) / 256;

    logic [EW-1:0]        cur_e, bnd_e, start_e, stop_e;
    logic signed [EW-1:0] avail_pg;

    // Free pages, then compare against the page count of a worst-case frame.
    always_comb begin
        cur_e   = EW'(cur_pg);
        bnd_e   = EW'(bnd_pg);
        start_e = EW'(start_pg);
        stop_e  = EW'(stop_pg);
        if (cur_e < bnd_e)
            avail_pg = $signed(bnd_e - cur_e);
        else
            avail_pg = $signed((stop_e - start_e) - (cur_e - bnd_e));
        full = int'(avail_pg) < NEED_PG;
    end

endmodule

// File: rtl/rxr_page_math.sv
// Next-page calculation: rounds the stored length plus header and trailer
// up to whole pages and wraps past the stop page. Combinational.
// Assumes start < stop.
module rxr_page_math #(
    parameter int PAGE_W = 8,
    parameter int LEN_W  = 12
) (
    input  logic [PAGE_W-1:0] cur_pg,
    input  logic [PAGE_W-1:0] start_pg,
    input  logic [PAGE_W-1:0] stop_pg,
    input  logic [LEN_W-1:0]  frame_len,
    output logic [PAGE_W-1:0] next_pg
);

    localparam int SW = ((PAGE_W > LEN_W) ? PAGE_W : LEN_W) + 2;

    logic [LEN_W:0] len_rnd;
    logic [SW-1:0]  span, sum, ring, nx;

    // Page span of header + data + trailer, then wrap into the ring.
    always_comb begin
        len_rnd = {1'b0, frame_len} + (LEN_W+1)'(263);
        span    = SW'(len_rnd >> 8);
        sum     = SW'(cur_pg) + span;
        ring    = SW'(stop_pg) - SW'(start_pg);
        nx      = (sum >= SW'(stop_pg)) ? (sum - ring) : sum;
        next_pg = PAGE_W'(nx);
    end

endmodule

// File: rtl/rxr_ring_writer.sv
// Receive ring writer: accepts a byte stream, filters by destination,
// stores frame bytes after a 4-byte header slot, pads runts, writes the
// header, then advances the current page and pulses rx_ok.
// Assumes ring configuration is stable while a frame is in flight and
// that cur_load is used only between frames.
module rxr_ring_writer
    import rxr_pkg::*;
#(
    parameter int PAGE_W    = 8,
    parameter int LEN_W     = 12,
    parameter int MAX_FRAME = 1514,
    parameter int MIN_FRAME = 60
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_stop,
    input  logic                 accept_all,
    input  logic                 accept_bcast,
    input  logic                 accept_mcast,
    input  logic [63:0]          mcast_hash,
    input  logic [47:0]          station_addr,
    input  logic [PAGE_W-1:0]    ring_start_pg,
    input  logic [PAGE_W-1:0]    ring_stop_pg,
    input  logic [PAGE_W-1:0]    boundary_pg,
    input  logic                 cur_load,
    input  logic [PAGE_W-1:0]    cur_load_pg,
    input  logic                 in_valid,
    input  logic                 in_sof,
    input  logic                 in_eof,
    input  logic [7:0]           in_data,
    output logic                 mem_we,
    output logic [PAGE_W+7:0]    mem_addr,
    output logic [7:0]           mem_wdata,
    output logic [PAGE_W-1:0]    cur_pg,
    output logic                 rx_ok
);

    localparam int AW = PAGE_W + 8;

    rxr_state_e        state;
    logic [AW-1:0]     wptr, wptr_inc, wptr_nx;
    logic [LEN_W-1:0]  cnt, filled, pad_len;
    logic [47:0]       dest_q, dest_nx;
    logic              group_q;
    logic [LEN_W-1:0]  len_q;
    logic [1:0]        hdr_idx;
    logic [PAGE_W-1:0] cur_q, next_pg;
    logic [15:0]       tot_len;
    logic [7:0]        hdr_byte;
    logic              accept, is_group, full;

    rxr_addr_filter u_filter (
        .dest         (dest_nx),
        .station_addr (station_addr),
        .mcast_hash   (mcast_hash),
        .accept_all   (accept_all),
        .accept_bcast (accept_bcast),
        .accept_mcast (accept_mcast),
        .accept       (accept),
        .is_group     (is_group)
    );

    rxr_space_check #(.PAGE_W(PAGE_W), .MAX_FRAME(MAX_FRAME), .HDR(HDR_BYTES)) u_space (
        .cur_pg   (cur_q),
        .bnd_pg   (boundary_pg),
        .start_pg (ring_start_pg),
        .stop_pg  (ring_stop_pg),
        .full     (full)
    );

    rxr_page_math #(.PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_next (
        .cur_pg    (cur_q),
        .start_pg  (ring_start_pg),
        .stop_pg   (ring_stop_pg),
        .frame_len (len_q),
        .next_pg   (next_pg)
    );

    // Capture the destination byte carried by the current beat.
    always_comb begin
        dest_nx = dest_q;
        for (int i = 0; i < DEST_BYTES; i++) begin
            if (cnt == LEN_W'(i)) dest_nx[i*8 +: 8] = in_data;
        end
    end

    // Write pointer step with wrap from the stop page to the start page.
    always_comb begin
        wptr_inc = wptr + AW'(1);
        wptr_nx  = (wptr_inc == {ring_stop_pg, 8'h00}) ? {ring_start_pg, 8'h00} : wptr_inc;
        filled   = cnt + LEN_W'(1);
        pad_len  = (filled < LEN_W'(MIN_FRAME)) ? LEN_W'(MIN_FRAME) : filled;
    end

    // Header byte for the current header slot.
    always_comb begin
        tot_len = 16'(len_q) + 16'(HDR_BYTES);
        case (hdr_idx)
            2'd0:    hdr_byte = group_q ? 8'h21 : 8'h01;
            2'd1:    hdr_byte = 8'(next_pg);
            2'd2:    hdr_byte = tot_len[7:0];
            default: hdr_byte = tot_len[15:8];
        endcase
    end

    // Frame sequencer: admission, data, padding, header, commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            wptr      <= '0;
            cnt       <= '0;
            dest_q    <= '0;
            group_q   <= 1'b0;
            len_q     <= '0;
            hdr_idx   <= '0;
            cur_q     <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            rx_ok     <= 1'b0;
        end else begin
            mem_we <= 1'b0;
            rx_ok  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cur_load) cur_q <= cur_load_pg;
                    if (in_valid && in_sof) begin
                        if (rx_stop || full) begin
                            state <= in_eof ? ST_IDLE : ST_SKIP;
                        end else begin
                            mem_we    <= 1'b1;
                            mem_addr  <= {cur_q, 8'h04};
                            mem_wdata <= in_data;
                            wptr      <= {cur_q, 8'h05};
                            cnt       <= LEN_W'(1);
                            dest_q    <= {40'h0, in_data};
                            state     <= in_eof ? ST_IDLE : ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    if (in_valid) begin
                        mem_we    <= 1'b1;
                        mem_addr  <= wptr;
                        mem_wdata <= in_data;
                        wptr      <= wptr_nx;
                        cnt       <= filled;
                        dest_q    <= dest_nx;
                        if (cnt == LEN_W'(DEST_BYTES - 1)) group_q <= is_group;
                        if (cnt == LEN_W'(DEST_BYTES - 1) && !accept) begin
                            state <= in_eof ? ST_IDLE : ST_SKIP;
                        end else if (in_eof) begin
                            hdr_idx <= '0;
                            len_q   <= pad_len;
                            if (filled < LEN_W'(DEST_BYTES))
                                state <= ST_IDLE;
                            else if (filled < LEN_W'(MIN_FRAME))
                                state <= ST_PAD;
                            else
                                state <= ST_HDR;
                        end
                    end
                end
                ST_SKIP: begin
                    if (in_valid && in_eof) state <= ST_IDLE;
                end
                ST_PAD: begin
                    mem_we    <= 1'b1;
                    mem_addr  <= wptr;
                    mem_wdata <= 8'h00;
                    wptr      <= wptr_nx;
                    cnt       <= filled;
                    if (filled >= len_q) state <= ST_HDR;
                end
                ST_HDR: begin
                    mem_we    <= 1'b1;
                    mem_addr  <= {cur_q, 6'b0, hdr_idx};
                    mem_wdata <= hdr_byte;
                    hdr_idx   <= hdr_idx + 2'd1;
                    if (hdr_idx == 2'd3) begin
                        cur_q <= next_pg;
                        rx_ok <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cur_pg = cur_q;

    // R12: the receive strobe lasts a single cycle.
    a_r12_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ok |=> !rx_ok);

    // R12: the strobe coincides with the final header write.
    a_r12_pulse_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ok |-> mem_we);

    // R12: the current page moves only on commit or a host load.
    a_r12_cur_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_pg != $past(cur_pg)) && !$past(cur_load)) |-> rx_ok);

    // R2: a start-of-frame seen while stopped writes nothing next cycle.
    a_r2_stopped_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && in_valid && in_sof && rx_stop) |=> !mem_we);

    // R11: every write lands inside the configured ring.
    a_r11_write_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && ring_start_pg < ring_stop_pg
         && cur_pg >= ring_start_pg && cur_pg < ring_stop_pg)
        |-> (mem_addr >= {ring_start_pg, 8'h00} && mem_addr < {ring_stop_pg, 8'h00}));

endmodule

// File: tb/rxr_ring_writer_tb_top.sv
`timescale 1ns/1ps
module rxr_ring_writer_tb_top;

    localparam logic [7:0] START = 8'h40;
    localparam logic [7:0] STOP  = 8'h50;
    localparam int         RING  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_stop = 1'b0;
    logic        accept_all = 1'b0, accept_bcast = 1'b0, accept_mcast = 1'b0;
    logic [63:0] mcast_hash = '0;
    logic [47:0] station_addr = 48'h5544_3322_1102;
    logic [7:0]  ring_start_pg = START, ring_stop_pg = STOP, boundary_pg = 8'h4F;
    logic        cur_load = 1'b0;
    logic [7:0]  cur_load_pg = '0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_data = '0;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  cur_pg;
    logic        rx_ok;

    int checks = 0;
    int errors = 0;
    int pulse_total = 0;
    bit fill_req = 1'b0;

    logic [7:0] mem_m [0:4095];
    logic [7:0] frm   [0:1599];
    logic [7:0] frm2  [0:1599];

    always #2.5 clk = ~clk;

    rxr_ring_writer dut_i (
        .clk(clk), .rst_n(rst_n), .rx_stop(rx_stop),
        .accept_all(accept_all), .accept_bcast(accept_bcast), .accept_mcast(accept_mcast),
        .mcast_hash(mcast_hash), .station_addr(station_addr),
        .ring_start_pg(ring_start_pg), .ring_stop_pg(ring_stop_pg), .boundary_pg(boundary_pg),
        .cur_load(cur_load), .cur_load_pg(cur_load_pg),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cur_pg(cur_pg), .rx_ok(rx_ok)
    );

    // Memory model of the ring region plus pulse counting.
    always @(posedge clk) begin
        if (fill_req) begin
            for (int i = 0; i < 4096; i++) mem_m[i] = 8'hEE;
        end else if (mem_we && mem_addr[15:12] == 4'h4) begin
            mem_m[mem_addr[11:0]] = mem_wdata;
        end
        if (rst_n && rx_ok) pulse_total = pulse_total + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] bench_hash(input logic [47:0] d);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < 48; i++) begin
            if (c[31] != d[i]) c = (c << 1) ^ 32'h04C11DB7;
            else               c = c << 1;
        end
        return c[31:26];
    endfunction

    task automatic set_frame(input logic [47:0] dest, input int seed);
        for (int i = 0; i < 1600; i++) frm[i] = 8'((i * 7 + seed * 13 + 1) & 255);
        for (int i = 0; i < 6; i++) frm[i] = dest[i*8 +: 8];
    endtask

    task automatic load_cur(input logic [7:0] pg, input logic [7:0] bnd);
        @(negedge clk); cur_load = 1'b1; cur_load_pg = pg; boundary_pg = bnd;
        @(negedge clk); cur_load = 1'b0;
    endtask

    task automatic bnd_behind();
        @(negedge clk);
        boundary_pg = (cur_pg == START) ? STOP - 8'd1 : cur_pg - 8'd1;
    endtask

    task automatic drive(input int len, input bit second);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == len - 1);
            in_data  = second ? frm2[i] : frm[i];
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    // Sends one frame (optionally a second one right behind it) and checks the outcome.
    task automatic run_frame(input string req, input int len, input bit acc, input bit chase);
        logic [7:0] old;
        int p0, plen, np, idx, bad;
        logic [7:0] exp;
        @(negedge clk);
        fill_req = 1'b1;
        @(negedge clk);
        fill_req = 1'b0;
        old = cur_pg;
        p0  = pulse_total;
        drive(len, 1'b0);
        if (chase) drive(80, 1'b1);
        repeat (90) @(negedge clk);
        if (acc) begin
            plen = (len < 60) ? 60 : len;
            np   = int'(old) + (plen + 8 + 255) / 256;
            if (np >= int'(STOP)) np = np - RING;
            chk({req, " next page"}, 32'(cur_pg), 32'(np));
            chk({req, " one pulse"}, 32'(pulse_total - p0), 32'd1);
            idx = (int'(old) - int'(START)) * 256;
            chk({req, " R9 status"}, 32'(mem_m[idx]), frm[0][0] ? 32'h21 : 32'h01);
            chk({req, " R9 next byte"}, 32'(mem_m[idx+1]), 32'(np));
            chk({req, " R9 length"}, {16'h0, mem_m[idx+3], mem_m[idx+2]}, 32'(plen + 4));
            bad = 0;
            idx = idx + 4;
            for (int k = 0; k < plen; k++) begin
                exp = (k < len) ? frm[k] : 8'h00;
                if (mem_m[idx] !== exp) bad++;
                idx = (idx + 1 == RING * 256) ? 0 : idx + 1;
            end
            chk({req, " R11 data"}, 32'(bad), 32'd0);
        end else begin
            chk({req, " dropped cur"}, 32'(cur_pg), 32'(old));
            chk({req, " dropped pulse"}, 32'(pulse_total - p0), 32'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lens [13] = '{6, 30, 59, 60, 61, 247, 248, 249, 250, 504, 1000, 1514, 5};
        logic [47:0] mdest;
        logic [5:0]  hi;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk("R1 cur_pg", 32'(cur_pg), 32'h0);
        chk("R1 mem_we", 32'(mem_we), 32'h0);
        chk("R1 rx_ok", 32'(rx_ok), 32'h0);
        rst_n = 1'b1;
        load_cur(START, STOP - 8'd1);

        // R4 R8 R9 R10 R11: promiscuous length sweep, odd lengths as group frames
        accept_all = 1'b1;
        foreach (lens[j]) begin
            set_frame((lens[j] % 2) ? 48'h0000_0000_0003 : 48'h0000_0000_000A, j);
            bnd_behind();
            run_frame($sformatf("R4 R8 R10 len%0d", lens[j]), lens[j], lens[j] >= 6, 1'b0);
        end

        // R11: frame crossing the stop page; R10: next page landing on stop exactly
        load_cur(8'h4E, 8'h4D);
        set_frame(48'h0000_0000_000A, 20);
        run_frame("R11 wrap mid-frame", 1000, 1'b1, 1'b0);
        load_cur(8'h4F, 8'h4E);
        set_frame(48'h0000_0000_000A, 21);
        run_frame("R10 next on stop", 248, 1'b1, 1'b0);

        // R2: stopped controller
        rx_stop = 1'b1;
        set_frame(48'h0000_0000_000A, 22);
        run_frame("R2 stopped", 100, 1'b0, 1'b0);
        rx_stop = 1'b0;

        // R3: free space on both sides of the boundary
        load_cur(8'h44, 8'h49);
        run_frame("R3 five pages ahead", 100, 1'b0, 1'b0);
        load_cur(8'h44, 8'h4A);
        run_frame("R3 six pages ahead", 100, 1'b1, 1'b0);
        load_cur(8'h4C, 8'h41);
        run_frame("R3 five pages wrapped", 100, 1'b0, 1'b0);
        load_cur(8'h4C, 8'h42);
        run_frame("R3 six pages wrapped", 100, 1'b1, 1'b0);
        load_cur(8'h45, 8'h45);
        run_frame("R3 boundary equals current", 100, 1'b1, 1'b0);

        accept_all = 1'b0;
        // R7: unicast exact match
        set_frame(station_addr, 30);
        bnd_behind();
        run_frame("R7 unicast match", 64, 1'b1, 1'b0);
        set_frame(station_addr ^ 48'h0100_0000_0000, 31);
        bnd_behind();
        run_frame("R7 unicast last byte differs", 64, 1'b0, 1'b0);

        // R5: broadcast
        set_frame(48'hFFFF_FFFF_FFFF, 32);
        accept_bcast = 1'b0; accept_mcast = 1'b1; mcast_hash = '1;
        bnd_behind();
        run_frame("R5 broadcast disabled", 64, 1'b0, 1'b0);
        accept_bcast = 1'b1; accept_mcast = 1'b0; mcast_hash = '0;
        bnd_behind();
        run_frame("R5 broadcast enabled", 64, 1'b1, 1'b0);
        accept_bcast = 1'b0;

        // R6: multicast hash
        mdest = 48'h0100_005E_0001;
        hi = bench_hash(mdest);
        set_frame(mdest, 33);
        accept_mcast = 1'b1; mcast_hash = 64'h1 << hi;
        bnd_behind();
        run_frame("R6 hash bit set", 64, 1'b1, 1'b0);
        mcast_hash = ~(64'h1 << hi);
        bnd_behind();
        run_frame("R6 hash bit clear", 64, 1'b0, 1'b0);
        accept_mcast = 1'b0; mcast_hash = '1;
        bnd_behind();
        run_frame("R6 multicast disabled", 64, 1'b0, 1'b0);

        // R12: a second frame starting during the header phase is ignored
        accept_all = 1'b1;
        set_frame(48'h0000_0000_000A, 34);
        for (int i = 0; i < 1600; i++) frm2[i] = 8'h5A;
        bnd_behind();
        run_frame("R12 busy ignore", 60, 1'b1, 1'b1);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule